// File: doc/BRIEF.md
# Serial Frame Strobe Delay Generator

This block watches the timeslot marker on a shared PCM serial bus and produces a second, delayed marker. A second device on the same bus can then use that delayed marker to find its own timeslot. The marker input repeats at 8 kHz. The output pin takes a different meaning depending on the selected bus mode.

In strobe mode the input is an active-high strobe that spans one 8-bit timeslot. When that strobe ends, the block emits a new active-high strobe of the same 8-bit width, placed directly behind the first. The block may be clocked by the bit clock itself, or by a faster master clock such as 4096 kHz when the bit clock is only 128 or 256 kHz. A ratio input gives the number of clock cycles in one bit period.

In frame mode the clock is a bus clock with two cycles per bit. The input is an active-low frame pulse. The block copies that pulse, shifted four 8-bit channel timeslots later (64 clocks), and keeps its width. After reset, and after any change of mode, the output stays inactive until one complete input pulse has been seen.

Top module: `frame_strobe_delay`

## Requirements
- R1: After reset the output is at its inactive level: 0 in strobe mode (`frame_mode`=0) and 1 in frame mode (`frame_mode`=1).
- R2: An input pulse whose start was not seen after reset (or after a mode change) produces no output. Only a pulse whose start and end have both been observed arms the block.
- R3: In strobe mode, let edge F be the first clock edge that samples `strb_in` low after a seen high phase. `strb_dly` is still 0 after edge F and rises at edge F+1.
- R4: In strobe mode the output strobe lasts 8×`bit_div` clock cycles: it is high after edge F+8×`bit_div` and low after edge F+8×`bit_div`+1. A `bit_div` of 0 is treated as 1.
- R5: In strobe mode, a new complete input strobe that ends while the output strobe is active restarts the width count from that new end. The output stays high without a gap.
- R6: In frame mode the input is active low. Let edge S be the first edge that samples it low. `strb_dly` is still 1 after edge S+63 and falls at edge S+64.
- R7: In frame mode, let edge E be the first edge that samples the input high again. The output rises at edge E+64, so a pulse shorter than 60 clocks keeps its width.
- R8: In frame mode, a new frame pulse that starts before a pending delay has expired cancels the older pulse. Only the newer pulse is reproduced.
- R9: A change of `frame_mode` drives the output to the new mode's inactive level at the next clock edge. It also discards any pending count and clears the arming.
- R10: `bit_div` has no effect on frame-mode timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, master clock or bus clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_mode | input | 1 | 0 = strobe mode, 1 = frame mode |
| bit_div | input | RATIO_W (6) | Clock cycles per bit period in strobe mode; 0 is read as 1 |
| strb_in | input | 1 | Input strobe (active high) or frame pulse (active low) |
| strb_dly | output | 1 | Delayed strobe or frame pulse, same polarity as the input |

## Verification
Every result has a fixed cycle position, measured from the first edge that samples the input change. In strobe mode the output rises one edge after the sampled fall and drops 8×`bit_div`+1 edges after it. In frame mode each output edge follows the matching sampled input edge by exactly 64 edges. After a mode change the output settles on the very next edge.

The bench counts rising edges and drives its inputs on falling edges. It computes each target edge from the edge that first samples the input change. It then reads the output just after the target edge and just after the edge before it, so a result that arrives one cycle early or one cycle late is reported.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic {
    FSD_STROBE = 1'b0,
    FSD_FRAME  = 1'b1
  } fsd_mode_e;

  localparam int unsigned FSD_NUM_TIMERS = 3;
  localparam int unsigned TMR_WIDTH      = 0;
  localparam int unsigned TMR_START      = 1;
  localparam int unsigned TMR_END        = 2;

  function automatic int unsigned fsd_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned fsd_cnt_bits(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/fsd_pulse_detect.sv
module fsd_pulse_detect
  import fsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  fsd_mode_e mode,
  input  logic      pin,
  output logic      rise,
  output logic      fall,
  output logic      seen_rise,
  output logic      armed
);

  logic act_q;
  logic prev_q;

  // Normalised "pulse active" level; registers start as if inside a pulse
  // so that a pulse already present at reset or mode change is not counted.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      act_q     <= 1'b1;
      prev_q    <= 1'b1;
      seen_rise <= 1'b0;
      armed     <= 1'b0;
    end else begin
      act_q  <= (mode == FSD_FRAME) ? ~pin : pin;
      prev_q <= act_q;
      if (rise)
        seen_rise <= 1'b1;
      if (fall && seen_rise)
        armed <= 1'b1;
    end
  end

  assign rise = act_q & ~prev_q;
  assign fall = ~act_q & prev_q;

endmodule

// File: rtl/fsd_countdown.sv
module fsd_countdown #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  // High in the last cycle of a count; the user acts at the following edge.
  assign expire = (cnt == CNT_W'(1)) && !load && !clr;

endmodule

// File: rtl/fsd_out_stage.sv
module fsd_out_stage
  import fsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  fsd_mode_e mode,
  input  logic      fire,
  input  logic      w_expire,
  input  logic      s_expire,
  input  logic      e_expire,
  input  logic      armed,
  output logic      out_act,
  output logic      pin_out
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      out_act <= 1'b0;
    end else begin
      unique case (mode)
        FSD_STROBE: begin
          if (fire)
            out_act <= 1'b1;
          else if (w_expire)
            out_act <= 1'b0;
        end
        FSD_FRAME: begin
          if (s_expire && armed)
            out_act <= 1'b1;
          else if (e_expire)
            out_act <= 1'b0;
        end
        default: out_act <= 1'b0;
      endcase
    end
  end

  assign pin_out = (mode == FSD_FRAME) ? ~out_act : out_act;

endmodule

// File: rtl/frame_strobe_delay.sv
module frame_strobe_delay
  import fsd_pkg::*;
#(
  parameter int unsigned RATIO_W            = 6,
  parameter int unsigned SLOT_BITS          = 8,
  parameter int unsigned FRAME_CLKS_PER_BIT = 2,
  parameter int unsigned FRAME_DELAY_SLOTS  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_mode,
  input  logic [RATIO_W-1:0] bit_div,
  input  logic               strb_in,
  output logic               strb_dly
);

  localparam int unsigned FRAME_DELAY = SLOT_BITS * FRAME_CLKS_PER_BIT * FRAME_DELAY_SLOTS;
  localparam int unsigned MAX_WIDTH   = SLOT_BITS * ((1 << RATIO_W) - 1);
  localparam int unsigned CNT_W       = fsd_cnt_bits(fsd_max(FRAME_DELAY, MAX_WIDTH));

  fsd_mode_e mode_q;
  logic      mode_chg;

  always_ff @(posedge clk) begin
    mode_q <= fsd_mode_e'(frame_mode);
  end

  assign mode_chg = (fsd_mode_e'(frame_mode) != mode_q);

  logic rise, fall, seen_rise, armed;

  fsd_pulse_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mode_chg),
    .mode      (mode_q),
    .pin       (strb_in),
    .rise      (rise),
    .fall      (fall),
    .seen_rise (seen_rise),
    .armed     (armed)
  );

  logic [RATIO_W-1:0]        div_eff;
  logic [CNT_W-1:0]          w_len;
  logic [FSD_NUM_TIMERS-1:0] tmr_load;
  logic [CNT_W-1:0]          tmr_val [FSD_NUM_TIMERS];
  logic [FSD_NUM_TIMERS-1:0] tmr_expire;
  logic                      strobe_fire;

  always_comb begin
    div_eff = (bit_div == '0) ? RATIO_W'(1) : bit_div;
    w_len   = CNT_W'(SLOT_BITS) * CNT_W'(div_eff);

    strobe_fire = (mode_q == FSD_STROBE) && fall && seen_rise;

    tmr_load[TMR_WIDTH] = strobe_fire;
    tmr_load[TMR_START] = (mode_q == FSD_FRAME) && rise;
    tmr_load[TMR_END]   = (mode_q == FSD_FRAME) && fall && seen_rise;

    tmr_val[TMR_WIDTH]  = w_len;
    tmr_val[TMR_START]  = CNT_W'(FRAME_DELAY - 1);
    tmr_val[TMR_END]    = CNT_W'(FRAME_DELAY - 1);
  end

  for (genvar gi = 0; gi < FSD_NUM_TIMERS; gi++) begin : g_tmr
    fsd_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mode_chg),
      .load     (tmr_load[gi]),
      .load_val (tmr_val[gi]),
      .expire   (tmr_expire[gi])
    );
  end

  logic w_expire, s_expire, e_expire, out_act;

  assign w_expire = tmr_expire[TMR_WIDTH];
  assign s_expire = tmr_expire[TMR_START];
  assign e_expire = tmr_expire[TMR_END];

  fsd_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mode_chg),
    .mode     (mode_q),
    .fire     (strobe_fire),
    .w_expire (w_expire),
    .s_expire (s_expire),
    .e_expire (e_expire),
    .armed    (armed),
    .out_act  (out_act),
    .pin_out  (strb_dly)
  );

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_mode,
  input logic mode_q,
  input logic out_act,
  input logic armed,
  input logic fall,
  input logic seen_rise,
  input logic w_expire,
  input logic s_expire,
  input logic e_expire,
  input logic strb_dly
);

  assert_quiet_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_act);

  assert_strobe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !frame_mode && fall && seen_rise) |=> strb_dly);

  assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !frame_mode && out_act && !w_expire) |=> out_act);

  assert_frame_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && frame_mode && s_expire && armed) |=> !strb_dly);

  assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && frame_mode && e_expire && !(s_expire && armed)) |=> strb_dly);

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_mode != mode_q) |=> !out_act);

endmodule

bind frame_strobe_delay fsd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_mode (frame_mode),
  .mode_q     (mode_q),
  .out_act    (out_act),
  .armed      (armed),
  .fall       (fall),
  .seen_rise  (seen_rise),
  .w_expire   (w_expire),
  .s_expire   (s_expire),
  .e_expire   (e_expire),
  .strb_dly   (strb_dly)
);

// File: tb/tb_frame_strobe_delay.sv
module tb_frame_strobe_delay;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_mode = 1'b0;
  logic [5:0] bit_div = 6'd1;
  logic       strb_in = 1'b0;
  logic       strb_dly;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  frame_strobe_delay dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_mode (frame_mode),
    .bit_div    (bit_div),
    .strb_in    (strb_in),
    .strb_dly   (strb_dly)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic lvl, input logic [5:0] div);
    @(negedge clk);
    rst_n = 1'b0; frame_mode = m; strb_in = lvl; bit_div = div;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive the input now; returns the edge that first samples it.
  task automatic drive(input logic v, output int e);
    strb_in = v;
    e = cyc + 1;
  endtask

  task automatic strobe_pulse(input int hi_len, output int f);
    int r;
    drive(1'b1, r);
    repeat (hi_len) @(negedge clk);
    drive(1'b0, f);
  endtask

  task automatic t_reset_R1();
    do_reset(1'b0, 1'b0, 6'd1);
    check("R1 strobe idle", strb_dly, 1'b0);
    do_reset(1'b1, 1'b1, 6'd1);
    check("R1 frame idle", strb_dly, 1'b1);
  endtask

  task automatic t_unarmed_R2();
    int f;
    do_reset(1'b0, 1'b1, 6'd1);
    repeat (3) @(negedge clk);
    drive(1'b0, f);
    for (int k = 0; k <= 12; k += 4) begin
      wait_to(f + k);
      check("R2 strobe partial pulse", strb_dly, 1'b0);
    end
    do_reset(1'b1, 1'b0, 6'd1);
    repeat (3) @(negedge clk);
    drive(1'b1, f);
    for (int k = 60; k <= 70; k += 5) begin
      wait_to(f + k);
      check("R2 frame partial pulse", strb_dly, 1'b1);
    end
  endtask

  task automatic t_strobe_R3_R4(input logic [5:0] div);
    int f;
    int w;
    w = 8 * ((div == 0) ? 1 : int'(div));
    do_reset(1'b0, 1'b0, div);
    strobe_pulse(8, f);
    wait_to(f);
    check("R3 not before F+1", strb_dly, 1'b0);
    wait_to(f + 1);
    check("R3 rise at F+1", strb_dly, 1'b1);
    wait_to(f + w);
    check("R4 still high at F+W", strb_dly, 1'b1);
    wait_to(f + w + 1);
    check("R4 low at F+W+1", strb_dly, 1'b0);
  endtask

  task automatic t_retrigger_R5();
    int f1;
    int f2;
    do_reset(1'b0, 1'b0, 6'd2);
    strobe_pulse(8, f1);
    wait_to(f1 + 4);
    strobe_pulse(2, f2);
    wait_to(f1 + 17);
    check("R5 held past first width", strb_dly, 1'b1);
    wait_to(f2 + 16);
    check("R5 high at F2+W", strb_dly, 1'b1);
    wait_to(f2 + 17);
    check("R5 low at F2+W+1", strb_dly, 1'b0);
  endtask

  task automatic t_frame(input logic [5:0] div, input string tag);
    int s;
    int e;
    do_reset(1'b1, 1'b1, div);
    drive(1'b0, s);
    repeat (2) @(negedge clk);
    drive(1'b1, e);
    wait_to(s + 63);
    check({tag, " R6 high at S+63"}, strb_dly, 1'b1);
    wait_to(s + 64);
    check({tag, " R6 low at S+64"}, strb_dly, 1'b0);
    wait_to(e + 63);
    check({tag, " R7 low at E+63"}, strb_dly, 1'b0);
    wait_to(e + 64);
    check({tag, " R7 high at E+64"}, strb_dly, 1'b1);
  endtask

  task automatic t_restart_R8();
    int s1;
    int s2;
    int e;
    do_reset(1'b1, 1'b1, 6'd1);
    drive(1'b0, s1);
    repeat (2) @(negedge clk);
    drive(1'b1, e);
    wait_to(s1 + 19);
    drive(1'b0, s2);
    repeat (2) @(negedge clk);
    drive(1'b1, e);
    wait_to(s1 + 64);
    check("R8 older pulse dropped", strb_dly, 1'b1);
    wait_to(s2 + 63);
    check("R8 high at S2+63", strb_dly, 1'b1);
    wait_to(s2 + 64);
    check("R8 low at S2+64", strb_dly, 1'b0);
    wait_to(e + 64);
    check("R8 high at E2+64", strb_dly, 1'b1);
  endtask

  task automatic t_mode_R9();
    int f;
    int m;
    do_reset(1'b0, 1'b0, 6'd4);
    strobe_pulse(8, f);
    wait_to(f + 5);
    check("R9 strobe active before change", strb_dly, 1'b1);
    frame_mode = 1'b1;
    m = cyc + 1;
    wait_to(m);
    check("R9 frame inactive after change", strb_dly, 1'b1);
    wait_to(m + 40);
    check("R9 no output in frame after change", strb_dly, 1'b1);
    frame_mode = 1'b0;
    m = cyc + 1;
    wait_to(m);
    check("R9 strobe inactive after change back", strb_dly, 1'b0);
    wait_to(m + 34);
    check("R9 old width discarded", strb_dly, 1'b0);
    strobe_pulse(8, f);
    wait_to(f + 1);
    check("R9 rearmed by full strobe", strb_dly, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d actual hung expected done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_unarmed_R2();
    t_strobe_R3_R4(6'd1);
    t_strobe_R3_R4(6'd0);
    t_strobe_R3_R4(6'd4);
    t_retrigger_R5();
    t_frame(6'd1, "base");
    t_frame(6'd37, "R10 div 37");
    t_frame(6'd0, "R10 div 0");
    t_restart_R8();
    t_mode_R9();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule